// File: doc/BRIEF.md
# Concurrent Logic Implication Checker

This block is a runtime error monitor. It sits next to a sequential circuit and watches a vector of that circuit's internal signals. It holds a fixed list of implication rules. Each rule says that when one watched bit has a given value, another watched bit must have a given value. A rule breaks when its first bit, the antecedent, matches its value and its second bit, the consequent, does not. When a rule breaks, the block raises that rule's violation bit. It also sets a sticky error flag.

Rules come in three classes:
- **Same-cycle:** looks at both bits in the same cycle and is active from the first cycle after reset.
- **Settled same-cycle:** looks at both bits in the same cycle, but only holds for states the circuit reaches after at least one clock. It is therefore ignored in the first cycle after reset.
- **Cross-cycle:** samples the antecedent in one cycle and checks the consequent in the next cycle. This lets a flip-flop output that captured a late value be checked one cycle later.

A single violation can have many fault sites as its cause, so all violation bits are ORed into one error flag. That flag stays set until an explicit clear or a reset.

Top module: `impl_monitor`

## Requirements
- R1: Each rule occupies E_W = 2*IDX_W+5 bits of `cfg_i`, and rule i sits at bit offset i*E_W. Inside a rule, the fields run from the LSB upwards as follows:
  - consequent value: 1 bit
  - consequent index: IDX_W bits
  - antecedent value: 1 bit
  - antecedent index: IDX_W bits
  - class: 2 bits
  - enable: 1 bit, at the MSB
- R2: For an enabled rule of class 00 (same-cycle), `viol_o[i]` is high in the same cycle whenever `sig_i[ante_idx]==ante_val` and `sig_i[cons_idx]!=cons_val`. This applies from the first cycle after reset and also during reset.
- R3: A rule whose enable bit is 0, or whose class is 11, never raises its violation bit.
- R4: A rule of class 01 (settled same-cycle) follows the R2 condition. It is held low while reset is asserted and in the first cycle after reset is released.
- R5: For a rule of class 10 (cross-cycle), `viol_o[i]` is high in cycle t+1 when the antecedent matched in cycle t and `sig_i[cons_idx]!=cons_val` in cycle t+1.
- R6: A cross-cycle rule never flags in the first cycle after reset, whatever the antecedent was before or during reset.
- R7: `err_o` goes high on the clock edge after any bit of `viol_o` is high, unless `clr_err` is high at that edge.
- R8: Once high, `err_o` stays high until `clr_err` is sampled high or reset is asserted.
- R9: When `clr_err` is sampled high, `err_o` is low in the next cycle, even if a violation is present at that edge.
- R10: While `rst_n` is low, `err_o` is 0 and no class 01 or class 10 rule flags.
- R11: The antecedent value and the consequent value are independent per rule. Either can be 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_err | input | 1 | Clears the sticky error flag at the next edge |
| sig_i | input | SIG_W | Watched signals of the monitored circuit |
| cfg_i | input | N_IMPL*E_W | Static rule list, packed as in R1 |
| viol_o | output | N_IMPL | Violation bit for each rule |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions assume that `cfg_i` changes only while reset is held. The masks they build from the enable and class fields are only meaningful under that assumption. The bench reloads the rule list only inside a reset window.

The assertions also assume that `sig_i` and `clr_err` are stable around the clock edge. The bench changes them shortly after each rising edge and samples at the falling edge.

Stimulus has two parts. The first is a fault-free vector: for every enabled rule, the antecedent bit is driven to the opposite of its value. Stuck-at faults are then injected on randomly chosen bits. The second part is directed vectors in the first cycle after each reset, where every antecedent matches and every consequent fails. A second rule list with every polarity inverted is also exercised.

// File: rtl/impl_pkg.sv
package impl_pkg;

   // Rule class codes held in the 2-bit class field of each entry.
   typedef enum logic [1:0] {
      CLS_SAME    = 2'b00,
      CLS_SETTLED = 2'b01,
      CLS_CROSS   = 2'b10,
      CLS_NONE    = 2'b11
   } impl_cls_e;

   // Index width needed to address a watched vector of the given width.
   function automatic int unsigned idx_width(input int unsigned sig_w);
      return (sig_w > 1) ? $clog2(sig_w) : 1;
   endfunction

   // Width of one packed rule: enable, class, two indices, two values.
   function automatic int unsigned entry_width(input int unsigned idx_w);
      return 2 * idx_w + 5;
   endfunction

endpackage

// File: rtl/impl_history.sv
// One-bit history of valid cycles since reset. It is low during reset and
// during the first cycle after reset, and high from the second cycle onward.
module impl_history (
   input  logic clk,
   input  logic rst_n,
   output logic arm_o
);

   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   assign arm_o = seen_q;

endmodule

// File: rtl/impl_tap.sv
// Selects the antecedent and consequent bits of one rule and compares each
// against its expected value.
module impl_tap #(
   parameter int unsigned IDX_W = 4
) (
   input  logic [(2**IDX_W)-1:0] sig_pad,
   input  logic [IDX_W-1:0]      ante_idx,
   input  logic                  ante_val,
   input  logic [IDX_W-1:0]      cons_idx,
   input  logic                  cons_val,
   output logic                  ante_hit,
   output logic                  cons_bad
);

   always_comb begin
      ante_hit = (sig_pad[ante_idx] == ante_val);
      cons_bad = (sig_pad[cons_idx] != cons_val);
   end

endmodule

// File: rtl/impl_cross_reg.sv
// Holds the antecedent match of a cross-cycle rule across one clock edge and
// judges the consequent in the following cycle.
module impl_cross_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic is_cross,
   input  logic ante_hit,
   input  logic cons_bad,
   output logic viol
);

   logic ante_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ante_q <= 1'b0;
      else        ante_q <= is_cross & ante_hit;
   end

   assign viol = arm & is_cross & ante_q & cons_bad;

endmodule

// File: rtl/impl_sticky.sv
// ORs the violation bits of all rules and keeps the result until cleared.
module impl_sticky #(
   parameter int unsigned N_IMPL = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_err,
   input  logic [N_IMPL-1:0] viol,
   output logic              err_o
);

   logic err_q;
   logic any_viol;

   assign any_viol = |viol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (clr_err) err_q <= 1'b0;
      else if (any_viol) err_q <= 1'b1;
   end

   assign err_o = err_q;

endmodule

// File: rtl/impl_monitor.sv
module impl_monitor #(
   parameter int unsigned SIG_W    = 16,
   parameter int unsigned N_IMPL   = 8,
   parameter bit          CROSS_EN = 1'b1,
   localparam int unsigned IDX_W   = impl_pkg::idx_width(SIG_W),
   localparam int unsigned E_W     = impl_pkg::entry_width(IDX_W)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_err,
   input  logic [SIG_W-1:0]        sig_i,
   input  logic [N_IMPL*E_W-1:0]   cfg_i,
   output logic [N_IMPL-1:0]       viol_o,
   output logic                    err_o
);

   import impl_pkg::*;

   localparam int unsigned PAD_W   = 2 ** IDX_W;
   localparam int unsigned OFF_CV  = 0;
   localparam int unsigned OFF_CI  = 1;
   localparam int unsigned OFF_AV  = IDX_W + 1;
   localparam int unsigned OFF_AI  = IDX_W + 2;
   localparam int unsigned OFF_CLS = 2 * IDX_W + 2;
   localparam int unsigned OFF_EN  = 2 * IDX_W + 4;

   if (N_IMPL < 1 || N_IMPL > 32) begin : g_bad_n
      $error("impl_monitor: N_IMPL must lie in 1..32");
   end
   if (SIG_W < 2) begin : g_bad_w
      $error("impl_monitor: SIG_W must be at least 2");
   end

   // Watched vector padded to a power of two; indices past SIG_W read 0.
   logic [PAD_W-1:0]    sig_pad;
   logic                arm_q;
   logic [N_IMPL-1:0]   en_v;
   logic [2*N_IMPL-1:0] cls_v;

   if (PAD_W > SIG_W) begin : g_pad
      assign sig_pad = {{(PAD_W-SIG_W){1'b0}}, sig_i};
   end else begin : g_nopad
      assign sig_pad = sig_i;
   end

   impl_history u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .arm_o (arm_q)
   );

   for (genvar i = 0; i < N_IMPL; i++) begin : g_rule
      logic [E_W-1:0]   ent;
      logic [IDX_W-1:0] ante_idx;
      logic [IDX_W-1:0] cons_idx;
      logic             ante_val;
      logic             cons_val;
      logic [1:0]       cls;
      logic             ante_hit;
      logic             cons_bad;
      logic             same_viol;
      logic             cross_viol;

      assign ent      = cfg_i[i*E_W +: E_W];
      assign cons_val = ent[OFF_CV];
      assign cons_idx = ent[OFF_CI +: IDX_W];
      assign ante_val = ent[OFF_AV];
      assign ante_idx = ent[OFF_AI +: IDX_W];
      assign cls      = ent[OFF_CLS +: 2];
      assign en_v[i]  = ent[OFF_EN];
      assign cls_v[2*i +: 2] = cls;

      impl_tap #(.IDX_W(IDX_W)) u_tap (
         .sig_pad  (sig_pad),
         .ante_idx (ante_idx),
         .ante_val (ante_val),
         .cons_idx (cons_idx),
         .cons_val (cons_val),
         .ante_hit (ante_hit),
         .cons_bad (cons_bad)
      );

      always_comb begin
         same_viol = 1'b0;
         if (en_v[i] && ante_hit && cons_bad) begin
            if (cls == CLS_SAME)                same_viol = 1'b1;
            else if (cls == CLS_SETTLED && arm_q) same_viol = 1'b1;
         end
      end

      if (CROSS_EN) begin : g_cross
         impl_cross_reg u_xreg (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (arm_q),
            .is_cross (en_v[i] && (cls == CLS_CROSS)),
            .ante_hit (ante_hit),
            .cons_bad (cons_bad),
            .viol     (cross_viol)
         );
      end else begin : g_nocross
         assign cross_viol = 1'b0;
      end

      assign viol_o[i] = same_viol | cross_viol;
   end

   impl_sticky #(.N_IMPL(N_IMPL)) u_sticky (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_err (clr_err),
      .viol    (viol_o),
      .err_o   (err_o)
   );

endmodule

// File: rtl/impl_monitor_sva.sv
module impl_monitor_sva #(
   parameter int unsigned N_IMPL = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                clr_err,
   input logic [N_IMPL-1:0]   viol_o,
   input logic                err_o,
   input logic                arm,
   input logic [N_IMPL-1:0]   en_v,
   input logic [2*N_IMPL-1:0] cls_v
);

   logic [N_IMPL-1:0] same_mask;
   logic [N_IMPL-1:0] off_mask;

   for (genvar i = 0; i < N_IMPL; i++) begin : g_mask
      assign same_mask[i] = en_v[i] && (cls_v[2*i +: 2] == 2'b00);
      assign off_mask[i]  = !en_v[i] || (cls_v[2*i +: 2] == 2'b11);
   end

   p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((|viol_o) && !clr_err) |=> err_o);

   p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_o && !clr_err && !(|viol_o)) |=> !err_o);

   p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !clr_err) |=> err_o);

   p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_err |=> !err_o);

   p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_o & off_mask) == '0);

   p_first_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |-> ((viol_o & ~same_mask) == '0));

   p_arm_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> arm);

endmodule

bind impl_monitor impl_monitor_sva #(.N_IMPL(N_IMPL)) u_sva (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr_err (clr_err),
   .viol_o  (viol_o),
   .err_o   (err_o),
   .arm     (arm_q),
   .en_v    (en_v),
   .cls_v   (cls_v)
);

// File: tb/impl_monitor_tb.sv
module impl_monitor_tb;

   localparam int SIG_W  = 16;
   localparam int N_IMPL = 8;
   localparam int IDX_W  = 4;
   localparam int E_W    = 2 * IDX_W + 5;
   localparam time PERIOD = 10ns;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  clr_err = 1'b0;
   logic [SIG_W-1:0]      sig_i = '0;
   logic [N_IMPL*E_W-1:0] cfg_i = '0;
   logic [N_IMPL-1:0]     viol_o;
   logic                  err_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Reference state
   bit          m_hist = 1'b0;
   bit          m_err  = 1'b0;
   bit [N_IMPL-1:0] m_ante = '0;
   bit [N_IMPL-1:0] m_exp  = '0;

   always #(PERIOD/2) clk = ~clk;

   impl_monitor #(.SIG_W(SIG_W), .N_IMPL(N_IMPL)) u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_err (clr_err),
      .sig_i   (sig_i),
      .cfg_i   (cfg_i),
      .viol_o  (viol_o),
      .err_o   (err_o)
   );

   // R1: field packing, LSB first: cons_val, cons_idx, ante_val, ante_idx, class, enable
   function automatic logic [E_W-1:0] mk(input bit en, input int cls, input int ai,
                                          input bit av, input int ci, input bit cv);
      logic [E_W-1:0] e;
      e = '0;
      e[0]               = cv;
      e[1 +: IDX_W]      = ci[IDX_W-1:0];
      e[IDX_W+1]         = av;
      e[IDX_W+2 +: IDX_W] = ai[IDX_W-1:0];
      e[2*IDX_W+2 +: 2]  = cls[1:0];
      e[2*IDX_W+4]       = en;
      return e;
   endfunction

   function automatic int f_cls(input int i);
      return int'(cfg_i[i*E_W + 2*IDX_W + 2 +: 2]);
   endfunction
   function automatic bit f_en(input int i);
      return cfg_i[i*E_W + 2*IDX_W + 4];
   endfunction
   function automatic int f_ai(input int i);
      return int'(cfg_i[i*E_W + IDX_W + 2 +: IDX_W]);
   endfunction
   function automatic bit f_av(input int i);
      return cfg_i[i*E_W + IDX_W + 1];
   endfunction
   function automatic int f_ci(input int i);
      return int'(cfg_i[i*E_W + 1 +: IDX_W]);
   endfunction
   function automatic bit f_cv(input int i);
      return cfg_i[i*E_W];
   endfunction

   function automatic string req_of(input int i);
      if (!f_en(i) || f_cls(i) == 3) return "R3";
      case (f_cls(i))
         0: return "R2 R11";
         1: return "R4 R10";
         default: return "R5 R6";
      endcase
   endfunction

   // Fault-free vector: every enabled antecedent held at its non-matching value.
   function automatic logic [SIG_W-1:0] golden();
      logic [SIG_W-1:0] s;
      s = SIG_W'($urandom);
      for (int i = 0; i < N_IMPL; i++)
         if (f_en(i)) s[f_ai(i)] = !f_av(i);
      return s;
   endfunction

   task automatic check_now();
      bit hit, bad;
      if (!rst_n) begin
         m_hist = 1'b0; m_ante = '0; m_err = 1'b0;
      end
      for (int i = 0; i < N_IMPL; i++) begin
         hit = (sig_i[f_ai(i)] == f_av(i));
         bad = (sig_i[f_ci(i)] != f_cv(i));
         m_exp[i] = 1'b0;
         if (f_en(i)) begin
            case (f_cls(i))
               0: m_exp[i] = hit && bad;
               1: m_exp[i] = m_hist && hit && bad;
               2: m_exp[i] = m_hist && m_ante[i] && bad;
               default: m_exp[i] = 1'b0;
            endcase
         end
      end
      n_vec++;
      for (int i = 0; i < N_IMPL; i++) begin
         if (viol_o[i] !== m_exp[i]) begin
            n_bad++;
            $display("FAIL %s rule %0d viol actual %b expected %b", req_of(i), i, viol_o[i], m_exp[i]);
         end
      end
      if (err_o !== m_err) begin
         n_bad++;
         $display("FAIL %s err_o actual %b expected %b",
                  rst_n ? "R7 R8 R9" : "R10", err_o, m_err);
      end
   endtask

   task automatic cycle(input logic [SIG_W-1:0] s, input logic c, input logic r);
      @(posedge clk);
      if (rst_n) begin
         for (int i = 0; i < N_IMPL; i++)
            m_ante[i] = f_en(i) && f_cls(i) == 2 && (sig_i[f_ai(i)] == f_av(i));
         m_err  = clr_err ? 1'b0 : (m_err | (|m_exp));
         m_hist = 1'b1;
      end else begin
         m_ante = '0; m_err = 1'b0; m_hist = 1'b0;
      end
      #1;
      sig_i = s; clr_err = c; rst_n = r;
      @(negedge clk);
      check_now();
   endtask

   // Every antecedent matches and every consequent fails.
   function automatic logic [SIG_W-1:0] all_bad();
      logic [SIG_W-1:0] s;
      s = '0;
      for (int i = 0; i < N_IMPL; i++) begin
         s[f_ai(i)] = f_av(i);
         s[f_ci(i)] = !f_cv(i);
      end
      return s;
   endfunction

   task automatic run_phase(input int n);
      logic [SIG_W-1:0] s;
      for (int k = 0; k < n; k++) begin
         s = golden();
         if ($urandom_range(3) == 0) begin
            int b;
            b = $urandom_range(SIG_W-1);
            s[b] = $urandom_range(1);          // stuck-at injection
         end
         if ($urandom_range(7) == 0) s = all_bad();
         cycle(s, ($urandom_range(15) == 0), 1'b1);
      end
   endtask

   task automatic load_cfg(input bit inv);
      cfg_i = '0;
      cfg_i[0*E_W +: E_W] = mk(1, 0,  0, 1^inv,  1, 1^inv);
      cfg_i[1*E_W +: E_W] = mk(1, 0,  2, 0^inv,  3, 0^inv);
      cfg_i[2*E_W +: E_W] = mk(1, 1,  4, 1^inv,  5, 0^inv);
      cfg_i[3*E_W +: E_W] = mk(1, 2,  6, 1^inv,  7, 1^inv);
      cfg_i[4*E_W +: E_W] = mk(1, 2,  8, 0^inv,  9, 1^inv);
      cfg_i[5*E_W +: E_W] = mk(0, 0, 10, 1^inv, 11, 1^inv);
      cfg_i[6*E_W +: E_W] = mk(1, 3, 12, 1^inv, 13, 1^inv);
      cfg_i[7*E_W +: E_W] = mk(1, 0, 14, 1^inv, 15, 0^inv);
   endtask

   initial begin
      load_cfg(1'b0);
      // R10: reset held, antecedents matching throughout
      for (int k = 0; k < 3; k++) cycle(all_bad(), 1'b0, 1'b0);
      // R4 R6: first cycle after release, all rules stressed
      cycle(all_bad(), 1'b0, 1'b1);
      cycle(all_bad(), 1'b0, 1'b1);
      // R9: clear while a violation is present
      cycle(all_bad(), 1'b1, 1'b1);
      cycle(golden(), 1'b0, 1'b1);
      // R8: hold with quiet inputs
      for (int k = 0; k < 4; k++) cycle(golden(), 1'b0, 1'b1);
      run_phase(400);
      // mid-run reset with the antecedents matching (R6)
      cycle(all_bad(), 1'b0, 1'b0);
      cycle(all_bad(), 1'b0, 1'b1);
      run_phase(200);
      // R11: inverted polarities, loaded under reset
      cycle(golden(), 1'b0, 1'b0);
      load_cfg(1'b1);
      cycle(all_bad(), 1'b0, 1'b0);
      cycle(all_bad(), 1'b0, 1'b1);
      run_phase(400);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule